// File: doc/BRIEF.md
# Two-Sided Doorbell Mailbox

This block joins two agents, a requester and a host, through a small message mailbox. Each side owns a bank of outgoing message words. The first word carries a request or message code and the rest carry data. Each side also owns an outgoing control register with a valid flag. The peer reads those same words through its incoming window. The peer sees the valid flag in its incoming control register one clock later.

The receiver answers by writing an acknowledge request to its incoming control register. The acknowledge reaches the sender's outgoing control register one clock later. The handshake is cross-coupled. When the sender drops its valid flag, the receiver's valid and acknowledge both clear on the next clock, and one clock after that the sender's acknowledge clears. A sender can therefore tell a fresh acknowledge from a stale one. Each side has two interrupt enables: one for an incoming valid message and one for a returned acknowledge. Each interrupt output is a level.

Both sides use the same word-addressed map. With the default of four message words:

| Address | Name | Access |
|---|---|---|
| 0-3 | Outgoing words | read/write |
| 4-7 | Incoming words, the peer's outgoing words | read only |
| 8 | Outgoing control | bit 0 valid, read/write; bit 1 acknowledge, read only |
| 9 | Incoming control | bit 0 valid, read only; bit 1 acknowledge, set by a write with bit 1 at 1 |
| 10 | Interrupt enables | bit 0 valid enable; bit 1 acknowledge enable |

Writes take effect at the rising clock edge. Reads are combinational.

Top module: `dbm_top`

## Requirements
- R1: After reset, every address on both sides reads 0, and all four interrupt outputs are low.
- R2: A word written at outgoing address i (0-3) reads back at address i on the same side. It also reads at address 4+i on the peer side from the cycle after the write edge.
- R3: Writes to incoming word addresses 4-7 are ignored. The writer's outgoing words and the peer's view of them are unchanged.
- R4: Bit 0 of a side's incoming control register (address 9) equals the peer's outgoing valid (address 8, bit 0) one clock later. It does not change in the same cycle.
- R5: A write to address 9 with bit 1 set sets the incoming acknowledge (address 9, bit 1), but only while the incoming valid is held by the peer. A write with bit 1 clear, or a write when no message is valid, has no effect.
- R6: Bit 1 of the outgoing control register (address 8) equals the peer's incoming acknowledge one clock after that acknowledge changes.
- R7: When a sender clears its outgoing valid, the receiver's incoming valid and acknowledge clear one clock later. The sender's outgoing acknowledge clears one clock after that.
- R8: Writes to read-only control bits have no effect. These bits are outgoing acknowledge (address 8, bit 1) and incoming valid (address 9, bit 0).
- R9: The valid interrupt output is high exactly while the incoming valid is 1 and the valid enable (address 10, bit 0) is 1.
- R10: The acknowledge interrupt output is high exactly while the outgoing acknowledge is 1 and the acknowledge enable (address 10, bit 1) is 1.
- R11: The interrupt enable register (address 10) reads back the two enable bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Requester write strobe |
| req_addr | input | AW (4) | Requester word address |
| req_wdata | input | DW (32) | Requester write data |
| req_rdata | output | DW (32) | Requester read data, combinational |
| req_irq_valid | output | 1 | Requester incoming-message interrupt |
| req_irq_ack | output | 1 | Requester acknowledge-returned interrupt |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW (4) | Host word address |
| host_wdata | input | DW (32) | Host write data |
| host_rdata | output | DW (32) | Host read data, combinational |
| host_irq_valid | output | 1 | Host incoming-message interrupt |
| host_irq_ack | output | 1 | Host acknowledge-returned interrupt |

## Verification
The bench samples each flag in the cycle a write lands and again one and two cycles later. A design with no mirror delay, or one that skips a stage of the clear chain, fails the lag checks. An acknowledge written while no message is valid must leave no trace. A design that latches it regardless would return a phantom acknowledge to the sender. It would also clear that acknowledge early when valid drops. Writes into the incoming window and into read-only bits must change nothing. A design that decodes these writes loosely would corrupt the peer's view of the words or forge an acknowledge. Both interrupt levels are checked as the enables and flags toggle. This catches an interrupt that ignores its enable or latches past its cause.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int FLAG_VALID = 0;
  localparam int FLAG_ACK   = 1;
  localparam int EN_VALID   = 0;
  localparam int EN_ACK     = 1;

  function automatic int unsigned tx_ctl_addr(input int unsigned nw);
    return 2 * nw;
  endfunction

  function automatic int unsigned rx_ctl_addr(input int unsigned nw);
    return 2 * nw + 1;
  endfunction

  function automatic int unsigned irq_en_addr(input int unsigned nw);
    return 2 * nw + 2;
  endfunction

  function automatic logic is_rx_word(input int unsigned a, input int unsigned nw);
    return (a >= nw) && (a < 2 * nw);
  endfunction
endpackage

// File: rtl/dbm_flags.sv
module dbm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic peer_tx_valid,
  input  logic peer_rx_ack,
  input  logic ack_wr,
  output logic rx_valid,
  output logic rx_ack,
  output logic tx_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_ack   <= 1'b0;
      tx_ack   <= 1'b0;
    end else begin
      rx_valid <= peer_tx_valid;
      rx_ack   <= peer_tx_valid & (rx_ack | (ack_wr & rx_valid));
      tx_ack   <= peer_rx_ack;
    end
  end

  AST_RXV_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rx_valid == $past(peer_tx_valid)); // R4
  AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |-> rx_valid); // R5
  AST_TXACK_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tx_ack == $past(peer_rx_ack)); // R6
  AST_CLR_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(peer_tx_valid) |=> !rx_ack && !rx_valid); // R7
endmodule

// File: rtl/dbm_irq.sv
module dbm_irq (
  input  logic rx_valid,
  input  logic tx_ack,
  input  logic en_valid,
  input  logic en_ack,
  output logic irq_valid,
  output logic irq_ack
);
  always_comb begin
    irq_valid = rx_valid & en_valid;
    irq_ack   = tx_ack & en_ack;
  end
endmodule

// File: rtl/dbm_side.sv
module dbm_side #(
  parameter int DW = 32,
  parameter int NW = 4,
  parameter int AW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic [NW-1:0][DW-1:0]  peer_words,
  output logic [NW-1:0][DW-1:0]  own_words,
  output logic                   tx_valid,
  input  logic                   peer_tx_valid,
  input  logic                   peer_rx_ack,
  output logic                   rx_ack,
  output logic                   irq_valid,
  output logic                   irq_ack
);
  import dbm_pkg::*;

  localparam logic [AW-1:0] A_TXC = AW'(tx_ctl_addr(NW));
  localparam logic [AW-1:0] A_RXC = AW'(rx_ctl_addr(NW));
  localparam logic [AW-1:0] A_IEN = AW'(irq_en_addr(NW));

  logic rx_valid, tx_ack, en_valid, en_ack, ack_wr, rx_word_wr;

  assign ack_wr     = wr && (addr == A_RXC) && wdata[FLAG_ACK];
  assign rx_word_wr = wr && is_rx_word(int'(addr), NW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_words <= '0;
      tx_valid  <= 1'b0;
      en_valid  <= 1'b0;
      en_ack    <= 1'b0;
    end else if (wr) begin
      for (int i = 0; i < NW; i++)
        if (addr == AW'(i)) own_words[i] <= wdata;
      if (addr == A_TXC) tx_valid <= wdata[FLAG_VALID];
      if (addr == A_IEN) begin
        en_valid <= wdata[EN_VALID];
        en_ack   <= wdata[EN_ACK];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NW; i++) begin
      if (addr == AW'(i))      rdata = own_words[i];
      if (addr == AW'(NW + i)) rdata = peer_words[i];
    end
    if (addr == A_TXC) begin
      rdata[FLAG_VALID] = tx_valid;
      rdata[FLAG_ACK]   = tx_ack;
    end
    if (addr == A_RXC) begin
      rdata[FLAG_VALID] = rx_valid;
      rdata[FLAG_ACK]   = rx_ack;
    end
    if (addr == A_IEN) begin
      rdata[EN_VALID] = en_valid;
      rdata[EN_ACK]   = en_ack;
    end
  end

  dbm_flags u_flags (
    .clk(clk), .rst_n(rst_n), .peer_tx_valid(peer_tx_valid),
    .peer_rx_ack(peer_rx_ack), .ack_wr(ack_wr),
    .rx_valid(rx_valid), .rx_ack(rx_ack), .tx_ack(tx_ack)
  );

  dbm_irq u_irq (
    .rx_valid(rx_valid), .tx_ack(tx_ack), .en_valid(en_valid), .en_ack(en_ack),
    .irq_valid(irq_valid), .irq_ack(irq_ack)
  );

  AST_RX_WORDS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_wr |=> $stable(own_words)); // R3
  AST_IRQV_NEEDS_RXV: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> rx_valid); // R9
  AST_IRQA_NEEDS_TXACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> tx_ack); // R10
endmodule

// File: rtl/dbm_top.sv
module dbm_top #(
  parameter int DW = 32,
  parameter int NW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] req_rdata,
  output logic          req_irq_valid,
  output logic          req_irq_ack,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq_valid,
  output logic          host_irq_ack
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0]                 s_wr, s_txv, s_rxack, s_irqv, s_irqa;
  logic [NSIDE-1:0][AW-1:0]         s_addr;
  logic [NSIDE-1:0][DW-1:0]         s_wdata, s_rdata;
  logic [NSIDE-1:0][NW-1:0][DW-1:0] s_words;

  assign s_wr    = {host_wr, req_wr};
  assign s_addr  = {host_addr, req_addr};
  assign s_wdata = {host_wdata, req_wdata};
  assign req_rdata      = s_rdata[0];
  assign host_rdata     = s_rdata[1];
  assign req_irq_valid  = s_irqv[0];
  assign host_irq_valid = s_irqv[1];
  assign req_irq_ack    = s_irqa[0];
  assign host_irq_ack   = s_irqa[1];

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam int PEER = NSIDE - 1 - g;
    dbm_side #(.DW(DW), .NW(NW), .AW(AW)) u_side (
      .clk(clk), .rst_n(rst_n),
      .wr(s_wr[g]), .addr(s_addr[g]), .wdata(s_wdata[g]), .rdata(s_rdata[g]),
      .peer_words(s_words[PEER]), .own_words(s_words[g]),
      .tx_valid(s_txv[g]), .peer_tx_valid(s_txv[PEER]),
      .peer_rx_ack(s_rxack[PEER]), .rx_ack(s_rxack[g]),
      .irq_valid(s_irqv[g]), .irq_ack(s_irqa[g])
    );
  end
endmodule

// File: tb/dbm_top_tb.sv
`timescale 1ns/1ps
module dbm_top_tb;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int REQ = 0;
  localparam int HOST = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_wr = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] req_addr = '0, host_addr = '0;
  logic [DW-1:0] req_wdata = '0, host_wdata = '0;
  logic [DW-1:0] req_rdata, host_rdata;
  logic req_irq_valid, req_irq_ack, host_irq_valid, host_irq_ack;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbm_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .req_irq_valid(req_irq_valid), .req_irq_ack(req_irq_ack),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq_valid(host_irq_valid), .host_irq_ack(host_irq_ack)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int side, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    if (side == REQ) begin req_wr = 1'b1; req_addr = AW'(a); req_wdata = d; end
    else begin host_wr = 1'b1; host_addr = AW'(a); host_wdata = d; end
    @(negedge clk);
    req_wr = 1'b0;
    host_wr = 1'b0;
  endtask

  task automatic rd(input int side, input int a, output logic [DW-1:0] d);
    if (side == REQ) req_addr = AW'(a); else host_addr = AW'(a);
    #0.5;
    d = (side == REQ) ? req_rdata : host_rdata;
  endtask

  task automatic expect_rd(input string req, input int side, input int a, input logic [DW-1:0] exp);
    logic [DW-1:0] d;
    rd(side, a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    int bad = 0;
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 11; a++) begin
        rd(s, a, d);
        if (d != 0) bad++;
      end
    check("R1 all registers zero", DW'(bad), 0);
    check("R1 irqs low", DW'({req_irq_valid, req_irq_ack, host_irq_valid, host_irq_ack}), 0);
  endtask

  task automatic t_words();
    for (int i = 0; i < 4; i++) wr(REQ, i, 32'hA5A50000 + DW'(i * 17));
    for (int i = 0; i < 4; i++) wr(HOST, i, 32'h3C000000 ^ DW'(i << 8));
    for (int i = 0; i < 4; i++) begin
      expect_rd("R2 req own word", REQ, i, 32'hA5A50000 + DW'(i * 17));
      expect_rd("R2 host sees req word", HOST, 4 + i, 32'hA5A50000 + DW'(i * 17));
      expect_rd("R2 req sees host word", REQ, 4 + i, 32'h3C000000 ^ DW'(i << 8));
    end
  endtask

  task automatic t_ro_words();
    wr(HOST, 4, 32'hDEADBEEF);
    wr(REQ, 7, 32'h12345678);
    expect_rd("R3 req word0 unchanged", REQ, 0, 32'hA5A50000);
    expect_rd("R3 host view unchanged", HOST, 4, 32'hA5A50000);
    expect_rd("R3 host word3 unchanged", HOST, 3, 32'h3C000300);
  endtask

  task automatic t_valid_mirror();
    wr(HOST, 10, 32'h1);
    expect_rd("R11 enable readback", HOST, 10, 32'h1);
    wr(REQ, 8, 32'h1);
    expect_rd("R4 no same-cycle mirror", HOST, 9, 32'h0);
    check("R9 irq waits for valid", DW'(host_irq_valid), 0);
    @(negedge clk);
    expect_rd("R4 valid mirrored", HOST, 9, 32'h1);
    check("R9 irq high", DW'(host_irq_valid), 1);
    expect_rd("R4 sender ctl", REQ, 8, 32'h1);
  endtask

  task automatic t_ro_bits();
    wr(HOST, 9, 32'h1);
    @(negedge clk);
    expect_rd("R8 rx valid bit write ignored", HOST, 9, 32'h1);
    wr(REQ, 8, 32'h3);
    @(negedge clk);
    expect_rd("R8 tx ack bit write ignored", REQ, 8, 32'h1);
  endtask

  task automatic t_ack();
    wr(REQ, 10, 32'h2);
    expect_rd("R11 ack enable readback", REQ, 10, 32'h2);
    wr(HOST, 9, 32'h2);
    expect_rd("R5 ack set", HOST, 9, 32'h3);
    expect_rd("R6 ack not yet mirrored", REQ, 8, 32'h1);
    check("R10 irq ack low before mirror", DW'(req_irq_ack), 0);
    @(negedge clk);
    expect_rd("R6 ack mirrored", REQ, 8, 32'h3);
    check("R10 irq ack high", DW'(req_irq_ack), 1);
  endtask

  task automatic t_clear();
    wr(REQ, 8, 32'h0);
    expect_rd("R7 receiver still set", HOST, 9, 32'h3);
    expect_rd("R7 sender ack held", REQ, 8, 32'h2);
    @(negedge clk);
    expect_rd("R7 receiver cleared", HOST, 9, 32'h0);
    check("R9 irq follows valid", DW'(host_irq_valid), 0);
    expect_rd("R7 sender ack one more cycle", REQ, 8, 32'h2);
    @(negedge clk);
    expect_rd("R7 sender ack cleared", REQ, 8, 32'h0);
    check("R10 irq ack follows", DW'(req_irq_ack), 0);
  endtask

  task automatic t_ack_no_valid();
    wr(HOST, 9, 32'h2);
    @(negedge clk);
    expect_rd("R5 ack without valid ignored", HOST, 9, 32'h0);
    @(negedge clk);
    expect_rd("R5 no phantom ack", REQ, 8, 32'h0);
  endtask

  task automatic t_irq_enable();
    wr(REQ, 8, 32'h1);
    @(negedge clk);
    check("R9 irq with enable", DW'(host_irq_valid), 1);
    wr(HOST, 10, 32'h0);
    check("R9 irq masked", DW'(host_irq_valid), 0);
    expect_rd("R9 flag stays", HOST, 9, 32'h1);
    wr(HOST, 9, 32'h2);
    @(negedge clk);
    check("R10 ack irq with enable", DW'(req_irq_ack), 1);
    wr(REQ, 10, 32'h0);
    check("R10 ack irq masked", DW'(req_irq_ack), 0);
    expect_rd("R10 ack flag stays", REQ, 8, 32'h3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_words();
    t_ro_words();
    t_valid_mirror();
    t_ro_bits();
    t_ack();
    t_clear();
    t_ack_no_valid();
    t_irq_enable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule